// File: doc/BRIEF.md
# Status Change Interrupt Generator

This block watches a vector of status bits and alerts a host processor when any of them moves. On every clock it compares the incoming status with the copy it took on the previous clock. Any difference, whether a bit rose or fell, sets a pending flag. The flag holds until the host signals that it has read the status register.

The interrupt line is modelled as an open-drain pin. The block gives a drive enable, which is high only while an interrupt is pending, and the logic level to put on the line while enabled. The inactive level is never driven; an external pull-up supplies it. In one bus-timing mode a polarity input picks the active level. In the other mode the line is always active-low.

Top module: `status_irq_gen`

## Requirements
- R1: After reset the drive enable `irq_oe_o` is 0. The first status value sampled after reset is only stored as the reference and never raises an interrupt.
- R2: If any status bit goes from 0 to 1 between two consecutive sampling edges, `irq_oe_o` is 1 after the second edge.
- R3: If any status bit goes from 1 to 0 between two consecutive sampling edges, `irq_oe_o` is 1 after the second edge.
- R4: While no read strobe is sampled, a pending interrupt stays asserted.
- R5: A read strobe (`stat_rd_i` = 1) sampled on an edge with no status change clears the pending interrupt, so `irq_oe_o` is 0 after that edge.
- R6: A status change sampled on the same edge as a read strobe leaves `irq_oe_o` at 1 after that edge. The change is not lost.
- R7: With `bus_mode_i` = 0, `irq_lvl_o` equals `pol_sel_i` (1 = active-high, 0 = active-low).
- R8: With `bus_mode_i` = 1, `irq_lvl_o` is 0 (active-low), whatever `pol_sel_i` is.
- R9: With no interrupt pending and the status unchanged, `irq_oe_o` stays 0, so the inactive level is never driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stat_i | input | STAT_W | Status bits being watched |
| stat_rd_i | input | 1 | One-cycle strobe: host read the status register |
| pol_sel_i | input | 1 | Active-level select, used only when bus_mode_i is 0 |
| bus_mode_i | input | 1 | Bus-timing mode; 1 forces an active-low line |
| irq_oe_o | output | 1 | Open-drain drive enable (interrupt pending) |
| irq_lvl_o | output | 1 | Level to drive while irq_oe_o is 1 |

## Verification
The bench targets four corner cases.

- First sample after reset: a design that treats it as a change fires a spurious interrupt at start-up.
- Read strobe arriving together with a status change: a design that lets the clear win drops that event.
- A bit falling rather than rising: a rising-only detector misses it.
- Bus mode 1 with the polarity input high: a design that ignores the mode drives an active-high level.

Random status and read traffic then checks that a pending flag survives cycles without a read, and that idle cycles never enable the driver.

// File: rtl/status_irq_pkg.sv
package status_irq_pkg;

    // Active level of the interrupt line while driven
    typedef enum logic {
        IRQ_ACT_LOW  = 1'b0,
        IRQ_ACT_HIGH = 1'b1
    } irq_level_e;

    // Pending state register
    typedef struct packed {
        logic pend;
    } pend_state_t;

    // Resolve the active level from mode and polarity select
    function automatic irq_level_e pick_level(input logic bus_mode, input logic pol_sel);
        if (bus_mode)
            return IRQ_ACT_LOW;
        return pol_sel ? IRQ_ACT_HIGH : IRQ_ACT_LOW;
    endfunction

endpackage

// File: rtl/stat_snap.sv
// Holds the previous status sample and flags any bit difference
module stat_snap #(
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] stat_i,
    output logic              chg_o
);
    typedef struct packed {
        logic [STAT_W-1:0] snap;
        logic              armed;
    } snap_state_t;

    snap_state_t st_d, st_q;
    logic [STAT_W-1:0] diff;

    genvar gi;
    generate
        for (gi = 0; gi < STAT_W; gi++) begin : g_bit
            assign diff[gi] = stat_i[gi] ^ st_q.snap[gi];
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        st_d.snap  = stat_i;
        st_d.armed = 1'b1;
        chg_o      = st_q.armed && (|diff);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pend_latch.sv
// Pending flag: set by a change, cleared by a read, set wins on a tie
module pend_latch
    import status_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic chg_i,
    input  logic clr_i,
    output logic pend_o
);
    pend_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = chg_i | (st_q.pend & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
endmodule

// File: rtl/irq_drive.sv
// Open-drain style output: enable only while pending, level from mode/polarity
module irq_drive
    import status_irq_pkg::*;
(
    input  logic pend_i,
    input  logic pol_sel_i,
    input  logic bus_mode_i,
    output logic oe_o,
    output logic lvl_o
);
    irq_level_e lvl;

    always_comb begin
        lvl   = pick_level(bus_mode_i, pol_sel_i);
        lvl_o = (lvl == IRQ_ACT_HIGH);
        oe_o  = pend_i;
    end
endmodule

// File: rtl/status_irq_gen.sv
module status_irq_gen #(
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] stat_i,
    input  logic              stat_rd_i,
    input  logic              pol_sel_i,
    input  logic              bus_mode_i,
    output logic              irq_oe_o,
    output logic              irq_lvl_o
);
    logic chg;
    logic pend;

    stat_snap #(.STAT_W(STAT_W)) snap_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .stat_i (stat_i),
        .chg_o  (chg)
    );

    pend_latch pend_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .chg_i  (chg),
        .clr_i  (stat_rd_i),
        .pend_o (pend)
    );

    irq_drive drv_i (
        .pend_i     (pend),
        .pol_sel_i  (pol_sel_i),
        .bus_mode_i (bus_mode_i),
        .oe_o       (irq_oe_o),
        .lvl_o      (irq_lvl_o)
    );
endmodule

// File: rtl/status_irq_chk.sv
module status_irq_chk #(
    parameter int STAT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [STAT_W-1:0] stat_i,
    input logic              stat_rd_i,
    input logic              pol_sel_i,
    input logic              bus_mode_i,
    input logic              irq_oe_o,
    input logic              irq_lvl_o
);
    logic [STAT_W-1:0] last_q;
    logic              seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= '0;
            seen_q <= 1'b0;
        end else begin
            last_q <= stat_i;
            seen_q <= 1'b1;
        end
    end

    // R1
    first_sample_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |=> !irq_oe_o);

    // R2
    change_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && (stat_i != last_q)) |=> irq_oe_o);

    // R4
    pend_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_oe_o && !stat_rd_i) |=> irq_oe_o);

    // R5
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && seen_q && (stat_i == last_q)) |=> !irq_oe_o);

    // R6
    tie_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && seen_q && (stat_i != last_q)) |=> irq_oe_o);

    // R7
    pol_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_mode_i |-> (irq_lvl_o == pol_sel_i));

    // R8
    forced_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_mode_i |-> !irq_lvl_o);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_oe_o && seen_q && (stat_i == last_q)) |=> !irq_oe_o);
endmodule

bind status_irq_gen status_irq_chk #(.STAT_W(STAT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat_i     (stat_i),
    .stat_rd_i  (stat_rd_i),
    .pol_sel_i  (pol_sel_i),
    .bus_mode_i (bus_mode_i),
    .irq_oe_o   (irq_oe_o),
    .irq_lvl_o  (irq_lvl_o)
);

// File: tb/status_irq_gen_tb.sv
`timescale 1ns/1ps
module status_irq_gen_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] stat;
    logic         rd, pol, mode;
    logic         oe, lvl;

    int total = 0;
    int bad = 0;

    // model state
    logic [W-1:0] m_last;
    logic         m_armed, m_pend;

    always #4 clk = ~clk;

    status_irq_gen #(.STAT_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .stat_i(stat), .stat_rd_i(rd),
        .pol_sel_i(pol), .bus_mode_i(mode), .irq_oe_o(oe), .irq_lvl_o(lvl)
    );

    function automatic logic exp_level(input logic md, input logic ps);
        return md ? 1'b0 : ps;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // called at a negedge: drive, check level, step model, check enable
    task automatic step(input logic [W-1:0] s, input logic r, input logic p, input logic m);
        logic         chg;
        logic [W-1:0] d;
        string        tag;
        stat = s; rd = r; pol = p; mode = m;
        #1;
        chk(m ? "R8" : "R7", lvl, exp_level(m, p));
        @(posedge clk);
        d   = s ^ m_last;
        chg = m_armed && (d != '0);
        if (!m_armed)           tag = "R1";
        else if (chg && r)      tag = "R6";
        else if (chg && |(s & d)) tag = "R2";
        else if (chg)           tag = "R3";
        else if (r)             tag = "R5";
        else if (m_pend)        tag = "R4";
        else                    tag = "R9";
        m_pend  = chg | (m_pend & ~r);
        m_last  = s;
        m_armed = 1'b1;
        @(negedge clk);
        chk(tag, oe, m_pend);
    endtask

    initial begin
        #2000000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; stat = 8'h00; rd = 1'b0; pol = 1'b0; mode = 1'b0;
        m_last = '0; m_armed = 1'b0; m_pend = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", oe, 1'b0);
        rst_n = 1'b1;

        // directed corner cases
        step(8'hA5, 1'b0, 1'b1, 1'b0); // R1 first sample stored only
        step(8'hA5, 1'b0, 1'b1, 1'b0); // R9 idle
        step(8'hA4, 1'b0, 1'b0, 1'b0); // R3 falling bit 0
        step(8'hA4, 1'b0, 1'b0, 1'b0); // R4 hold
        step(8'hA4, 1'b1, 1'b0, 1'b0); // R5 clear
        step(8'hA6, 1'b0, 1'b1, 1'b1); // R2 rising bit 1, R8 forced low
        step(8'hA7, 1'b1, 1'b0, 1'b1); // R6 change with read
        step(8'hA7, 1'b1, 1'b1, 1'b0); // R5 clear, R7 high
        step(8'hA7, 1'b0, 1'b1, 1'b1); // R9, R8

        // random traffic
        for (int i = 0; i < 400; i++) begin
            logic [W-1:0] s;
            s = stat;
            if ($urandom_range(0, 3) == 0)
                s = s ^ (8'h01 << $urandom_range(0, W-1));
            step(s, ($urandom_range(0, 4) == 0), 1'($urandom), 1'($urandom));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule